// File: doc/BRIEF.md
# Flash Sector Lock Protection Unit

This block holds the software write protection of a NOR flash command interface. It watches the bus write cycles that reach the flash, each a word address and a data word, and it recognises three keyed commands. The first locks the whole device. The second opens exactly one sector. The third fences off a run of sectors so that they can never be opened again until power is cycled. For each sector it stores a lock flag and a fence flag. A combinational query port tells the program and erase engines whether a target sector is locked.

The word address is split into three fields. Bits below `SECT_LSB` carry the key offsets 555h and 2AAh, as well as the open/close selector bit `SEL_BIT`. The next `SECT_W` bits hold the sector index. Any bits above that field are ignored. The power-on reset `por_n` is asynchronous and active low. It is the only way to clear the state.

Top module: `slk_unit`

## Requirements
- R1: While `por_n` is low, and after it is released, every sector reads as unlocked and no sector is fenced.
- R2: Three writes lock every sector: data 60h at key offset 555h, then 60h at key offset 2AAh, then 60h at an address whose bit 6 is 0. The sector field of the third write does not matter.
- R3: The same three writes with bit 6 set to 1 in the third write open the sector in address bits [14:12] and lock every other sector.
- R4: Opening a new sector locks the sector that was open before it, so at most one sector is open after an open command.
- R5: Four writes fence sectors: 60h at 555h, 60h at 2AAh, 61h at a sector address, then 61h at the same sector. This fences every sector from the last successfully opened sector (sector 0 if none has been opened since reset) to the addressed sector, inclusive, in either order. Lock flags are not changed.
- R6: An open command aimed at a fenced sector has no effect. The previously open sector stays open and all other lock flags stay as they were.
- R7: Fences survive every command, including lock-all. Only `por_n` low clears fences and lock flags.
- R8: A write that does not match the next expected cycle sends the decoder back to idle and changes no state. That write is not taken as the first cycle of a new sequence.
- R9: In a fence command, a fourth write at a sector other than the one in the third write aborts the command and fences nothing.
- R10: `qry_locked` shows the lock flag of `qry_sect` in the same cycle. A command takes effect at the clock edge that captures its last write, so during that write's cycle the query still returns the old value.
- R11: Only data bits [7:0] are decoded. The key offsets are compared on address bits [11:0] only, so the sector field and bit 15 are ignored in the first two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | A bus write cycle is present this clock |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data of the write |
| qry_sect | input | SECT_W | Sector index to query |
| qry_locked | output | 1 | 1 when the queried sector is locked |

## Verification
The query and the completion of a command can happen in the same clock. The bench provokes this by presenting the final write of a lock-all command while `qry_sect` points at the one open sector. It samples the query before the edge and expects the old "open" value, then samples again after the edge and expects "locked". A second collision comes from the fence command, whose range is anchored on the last opened sector. The bench fences a range that contains the open sector and then checks that this sector stays open while opens of other sectors inside the range are refused.

// File: rtl/slk_pkg.sv
package slk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_KEY1 = 2'd1,
      ST_KEY2 = 2'd2,
      ST_FENCE = 2'd3
   } slk_state_e;

   localparam logic [7:0]  CODE_LOCK  = 8'h60;
   localparam logic [7:0]  CODE_FENCE = 8'h61;
   localparam logic [10:0] KEY_OFS_A  = 11'h555;
   localparam logic [10:0] KEY_OFS_B  = 11'h2AA;
endpackage

// File: rtl/slk_decode.sv
module slk_decode
   import slk_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int SECT_LSB = 12,
   parameter int SECT_W   = 3,
   parameter int SEL_BIT  = 6
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              do_lock,
   output logic              do_unlock,
   output logic              do_fence,
   output logic [SECT_W-1:0] cmd_sect,
   output logic              idle
);
   localparam logic [SECT_LSB-1:0] OFS_A = SECT_LSB'(KEY_OFS_A);
   localparam logic [SECT_LSB-1:0] OFS_B = SECT_LSB'(KEY_OFS_B);

   slk_state_e        state_q, state_d;
   logic [SECT_W-1:0] fence_sect_q;
   logic [SECT_LSB-1:0] ofs;
   logic [7:0]        code;
   logic [SECT_W-1:0] sect_in;
   logic              unused_hi;

   assign ofs       = wr_addr[SECT_LSB-1:0];
   assign code      = wr_data[7:0];
   assign sect_in   = wr_addr[SECT_LSB +: SECT_W];
   assign unused_hi = ^{wr_addr, wr_data};
   assign idle      = (state_q == ST_IDLE);
   assign cmd_sect  = sect_in;

   always_comb begin
      state_d   = state_q;
      do_lock   = 1'b0;
      do_unlock = 1'b0;
      do_fence  = 1'b0;
      if (wr_en) begin
         case (state_q)
            ST_IDLE: begin
               if (ofs == OFS_A && code == CODE_LOCK) state_d = ST_KEY1;
            end
            ST_KEY1: begin
               state_d = (ofs == OFS_B && code == CODE_LOCK) ? ST_KEY2 : ST_IDLE;
            end
            ST_KEY2: begin
               state_d = ST_IDLE;
               if (code == CODE_LOCK) begin
                  if (wr_addr[SEL_BIT]) do_unlock = 1'b1;
                  else                  do_lock   = 1'b1;
               end else if (code == CODE_FENCE) begin
                  state_d = ST_FENCE;
               end
            end
            default: begin
               state_d = ST_IDLE;
               if (code == CODE_FENCE && sect_in == fence_sect_q) do_fence = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state_q      <= ST_IDLE;
         fence_sect_q <= '0;
      end else begin
         state_q <= state_d;
         if (wr_en && state_q == ST_KEY2) fence_sect_q <= sect_in;
      end
   end
endmodule

// File: rtl/slk_bank.sv
module slk_bank #(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                do_lock,
   input  logic                do_unlock,
   input  logic                do_fence,
   input  logic [SECT_W-1:0]   cmd_sect,
   output logic [NUM_SECT-1:0] lock_vec,
   output logic [NUM_SECT-1:0] prot_vec
);
   logic [NUM_SECT-1:0] lock_q, prot_q;
   logic [SECT_W-1:0]   last_q;
   logic [SECT_W-1:0]   lo, hi;
   logic                open_ok;

   assign open_ok  = do_unlock && !prot_q[cmd_sect];
   assign lo       = (last_q < cmd_sect) ? last_q : cmd_sect;
   assign hi       = (last_q < cmd_sect) ? cmd_sect : last_q;
   assign lock_vec = lock_q;
   assign prot_vec = prot_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       last_q <= '0;
      else if (open_ok) last_q <= cmd_sect;
   end

   for (genvar g = 0; g < NUM_SECT; g++) begin : g_sect
      localparam logic [SECT_W-1:0] IDX = SECT_W'(g);

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)       lock_q[g] <= 1'b0;
         else if (do_lock) lock_q[g] <= 1'b1;
         else if (open_ok) lock_q[g] <= (cmd_sect != IDX);
      end

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) prot_q[g] <= 1'b0;
         else if (do_fence && IDX >= lo && IDX <= hi) prot_q[g] <= 1'b1;
      end
   end
endmodule

// File: rtl/slk_unit.sv
module slk_unit #(
   parameter int NUM_SECT = 8,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int SECT_LSB = 12,
   parameter int SEL_BIT  = 6,
   localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SECT_W-1:0] qry_sect,
   output logic              qry_locked
);
   if (NUM_SECT < 2 || (1 << SECT_W) != NUM_SECT) begin : g_bad_count
      $error("slk_unit: NUM_SECT must be a power of two, at least 2");
   end
   if (SECT_LSB < 11) begin : g_bad_lsb
      $error("slk_unit: SECT_LSB too small for the key offsets");
   end
   if (SEL_BIT >= SECT_LSB) begin : g_bad_sel
      $error("slk_unit: SEL_BIT must lie below the sector field");
   end
   if (SECT_LSB + SECT_W > ADDR_W) begin : g_bad_addr
      $error("slk_unit: sector field exceeds ADDR_W");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("slk_unit: DATA_W must be at least 8");
   end

   logic                do_lock, do_unlock, do_fence, dec_idle;
   logic [SECT_W-1:0]   cmd_sect;
   logic [NUM_SECT-1:0] lock_vec, prot_vec;

   slk_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB),
      .SECT_W(SECT_W), .SEL_BIT(SEL_BIT)
   ) u_dec (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .do_lock(do_lock), .do_unlock(do_unlock),
      .do_fence(do_fence), .cmd_sect(cmd_sect), .idle(dec_idle)
   );

   slk_bank #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_bank (
      .clk(clk), .por_n(por_n), .do_lock(do_lock), .do_unlock(do_unlock),
      .do_fence(do_fence), .cmd_sect(cmd_sect),
      .lock_vec(lock_vec), .prot_vec(prot_vec)
   );

   assign qry_locked = lock_vec[qry_sect];
endmodule

// File: rtl/slk_chk.sv
module slk_chk #(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3
) (
   input logic                clk,
   input logic                por_n,
   input logic                wr_en,
   input logic                dec_idle,
   input logic                do_lock,
   input logic                do_unlock,
   input logic [SECT_W-1:0]   cmd_sect,
   input logic [NUM_SECT-1:0] lock_vec,
   input logic [NUM_SECT-1:0] prot_vec
);
   // R2
   lock_all_chk: assert property (@(posedge clk) disable iff (!por_n)
      do_lock |=> (&lock_vec));

   // R4
   single_open_chk: assert property (@(posedge clk) disable iff (!por_n)
      (do_unlock && !prot_vec[cmd_sect]) |=>
         ($countones(~lock_vec) == 1 && !lock_vec[$past(cmd_sect)]));

   // R6
   fenced_open_chk: assert property (@(posedge clk) disable iff (!por_n)
      (do_unlock && prot_vec[cmd_sect]) |=> $stable(lock_vec));

   // R7
   fence_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      ((prot_vec & $past(prot_vec)) == $past(prot_vec)));

   // R8
   idle_write_chk: assert property (@(posedge clk) disable iff (!por_n)
      (dec_idle && wr_en) |=> ($stable(lock_vec) && $stable(prot_vec)));
endmodule

bind slk_unit slk_chk #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_chk (
   .clk(clk), .por_n(por_n), .wr_en(wr_en), .dec_idle(dec_idle),
   .do_lock(do_lock), .do_unlock(do_unlock), .cmd_sect(cmd_sect),
   .lock_vec(lock_vec), .prot_vec(prot_vec)
);

// File: tb/sim_slk_unit.sv
module sim_slk_unit;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  qry_sect = '0;
   logic        qry_locked;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   slk_unit u0 (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .qry_sect(qry_sect), .qry_locked(qry_locked)
   );

   function automatic logic [15:0] mk(input int s, input logic [11:0] ofs);
      return {1'b0, 3'(s), ofs};
   endfunction

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic chk(input int s, input logic exp, input string req);
      qry_sect = 3'(s);
      #1;
      n_chk++;
      if (qry_locked !== exp) begin
         n_fail++;
         $display("FAIL %s sector %0d locked=%b expected=%b", req, s, qry_locked, exp);
      end
   endtask

   task automatic chk_only_open(input int s, input string req);
      for (int i = 0; i < 8; i++) chk(i, (i != s), req);
   endtask

   task automatic cmd_lock(input int s);
      wr(mk(s, 12'h555), 16'h0060); wr(mk(s, 12'h2AA), 16'h0060);
      wr(mk(s, 12'h000), 16'h0060);
   endtask

   task automatic cmd_open(input int s);
      wr(mk(0, 12'h555), 16'h0060); wr(mk(0, 12'h2AA), 16'h0060);
      wr(mk(s, 12'h040), 16'h0060);
   endtask

   task automatic cmd_fence(input int s3, input int s4);
      wr(mk(0, 12'h555), 16'h0060); wr(mk(0, 12'h2AA), 16'h0060);
      wr(mk(s3, 12'h000), 16'h0061); wr(mk(s4, 12'h000), 16'h0061);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) chk(i, 1'b0, "R1 during reset");
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) chk(i, 1'b0, "R1 after reset");
   endtask

   task automatic t_lock_open;
      cmd_lock(5);
      for (int i = 0; i < 8; i++) chk(i, 1'b1, "R2 lock all");
      cmd_open(3);
      chk_only_open(3, "R3 open one");
      cmd_open(6);
      chk_only_open(6, "R4 reopen");
   endtask

   task automatic t_same_cycle;
      wr(mk(1, 12'h555), 16'h0060); wr(mk(1, 12'h2AA), 16'h0060);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = mk(1, 12'h000); wr_data = 16'h0060;
      chk(6, 1'b0, "R10 old value before edge");
      @(negedge clk);
      wr_en = 1'b0;
      chk(6, 1'b1, "R10 new value after edge");
   endtask

   task automatic t_abort;
      wr(mk(0, 12'h555), 16'h0060); wr(mk(0, 12'h2AA), 16'h0070);
      wr(mk(0, 12'h2AA), 16'h0060); wr(mk(2, 12'h040), 16'h0060);
      chk(2, 1'b1, "R8 bad data abort");
      wr(mk(0, 12'h555), 16'h0060); wr(mk(0, 12'h555), 16'h0060);
      wr(mk(0, 12'h2AA), 16'h0060); wr(mk(2, 12'h040), 16'h0060);
      chk(2, 1'b1, "R8 bad address abort");
      wr(16'hD555, 16'hA560); wr(16'hB2AA, 16'h3C60);
      wr({1'b1, 3'd2, 12'h040}, 16'hFF60);
      chk_only_open(2, "R11 ignored upper bits");
   endtask

   task automatic t_fence;
      cmd_fence(5, 5);
      chk(2, 1'b0, "R5 lock flags kept");
      chk(5, 1'b1, "R5 lock flags kept");
      cmd_open(4);
      chk_only_open(2, "R6 open of fenced sector");
      cmd_open(6);
      chk_only_open(6, "R5 outside range opens");
      cmd_open(7);
      cmd_fence(6, 6);
      cmd_open(6);
      chk_only_open(7, "R6 reverse range fenced");
      cmd_open(0);
      chk_only_open(0, "R5 below range opens");
      cmd_fence(1, 3);
      cmd_open(1);
      chk_only_open(1, "R9 mismatched fence aborts");
   endtask

   task automatic t_persist;
      cmd_lock(0);
      cmd_open(3);
      for (int i = 0; i < 8; i++) chk(i, 1'b1, "R7 fence survives lock");
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) chk(i, 1'b0, "R7 reset clears");
      cmd_open(3);
      chk_only_open(3, "R7 fence cleared by reset");
   endtask

   initial begin
      t_reset();
      t_lock_open();
      t_same_cycle();
      t_abort();
      t_fence();
      t_persist();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule